// File: doc/BRIEF.md
# Instruction Cycle Penalty Calculator

This block works out how many bus cycles one instruction of a 16-bit-extended 6502-family processor will take. An instruction decoder supplies an instruction class code, an addressing-mode code and the cycle count the instruction takes with no penalties. Alongside these come the processor state that decides the variable part of the timing: the accumulator-width, index-width and emulation bits, the low byte of the direct-page register, the high bytes of the unindexed base address, the effective address and the program counter, and a branch-taken flag.

The block adds every penalty that applies and registers the total one clock after a valid input. A penalty is added only when both the instruction class and the addressing mode call for it. A timing model or cycle scheduler uses the result to decide when the next instruction may start. Instruction decoding and execution happen elsewhere.

Top module: `cyc_penalty_calc`

## Requirements
- R1: `out_valid` is high for exactly one clock, the clock after a clock with `in_valid` high. `out_cycles` is loaded on that edge and keeps its value while `in_valid` stays low.
- R2: For class 1 (accumulator operation, including loads) and class 2 (store), one cycle is added when `flag_m` is 0 (16-bit accumulator).
- R3: For the direct-page modes (mode codes 5 dp, 6 dp+X, 7 dp+Y, 8 (dp), 9 (dp,X), 10 (dp)+Y, 11 [dp], 12 [dp]+Y), one cycle is added whenever `dp_low` is nonzero, in any class.
- R4: For the read classes 1 and 6 in modes 3 (abs+X), 4 (abs+Y), 10 ((dp)+Y) and 12 ([dp]+Y), one cycle is added when `flag_x` is 0 (16-bit index) or when `base_hi` differs from `ea_hi`.
- R5: Class 2 (store) and class 3 (read-modify-write) never receive the index/page-cross cycle of R4, because their base count already contains it.
- R6: Class 3 (read-modify-write) adds two cycles when `flag_m` is 0, and none when it is 1.
- R7: Class 4 (branch) in mode 15 (relative) adds one cycle when `br_taken` is 1, and one more when `br_taken` is 1, `flag_e` is 1 and `ea_hi` differs from `pc_hi`.
- R8: Class 5 (break, coprocessor trap, interrupt return) adds one cycle when `flag_e` is 0 (native mode).
- R9: Class 6 (index compare or index load) adds one cycle when `flag_x` is 0.
- R10: Mode 13 (stack-relative) always adds one cycle. Mode 14 (stack-relative indirect, Y-indexed) always adds one cycle, plus a second one for the read classes 1 and 6. Both ignore `dp_low`, `flag_x` and the address bytes.
- R11: Class 7 (flag set/reset, accumulator byte swap) yields exactly 3 cycles whatever the base count and the other inputs.
- R12: While `rst` is high on a clock edge, `out_valid` and `out_cycles` become 0. Class 0 adds no class-specific penalty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | The inputs below describe one instruction |
| cls | input | 4 | Instruction class code (0..7) |
| mode | input | 4 | Addressing-mode code (0..15) |
| base_cnt | input | CNT_W (4) | Cycle count with no penalty |
| flag_m | input | 1 | 1 = 8-bit accumulator |
| flag_x | input | 1 | 1 = 8-bit index registers |
| flag_e | input | 1 | 1 = emulation mode |
| dp_low | input | 8 | Low byte of the direct-page register |
| base_hi | input | 8 | High byte of the unindexed base address |
| ea_hi | input | 8 | High byte of the effective or target address |
| pc_hi | input | 8 | High byte of the program counter |
| br_taken | input | 1 | Branch is taken |
| out_valid | output | 1 | One-clock pulse, total ready |
| out_cycles | output | CNT_W+1 (5) | Base count plus penalties |

## Verification
The hardest case to reach is when several penalties stack on one instruction. For example, a 16-bit-accumulator read in mode 12 with an unaligned direct page and a page cross gets three extra cycles. A taken emulation-mode branch is another: its second cycle depends on the high bytes alone. Uniform random inputs seldom make two address high bytes equal, so the random stimulus picks the effective-address high byte to equal its partner half of the time. Every flag and `dp_low` is also forced to zero in a share of the draws. Directed cases then pin each of these stacks down separately, and they also cover the store and read-modify-write modes where the page cross must be ignored.

// File: rtl/cyc_pkg.sv
package cyc_pkg;

    localparam int BYTE_W       = 8;
    localparam int CODE_W       = 4;
    localparam int PEN_W        = 2;
    localparam int FIXED_CYCLES = 3;

    typedef enum logic [CODE_W-1:0] {
        CLS_OTHER  = 4'd0,
        CLS_ACC    = 4'd1,
        CLS_STORE  = 4'd2,
        CLS_RMW    = 4'd3,
        CLS_BRANCH = 4'd4,
        CLS_TRAP   = 4'd5,
        CLS_IDX    = 4'd6,
        CLS_FIXED  = 4'd7
    } instr_cls_e;

    typedef enum logic [CODE_W-1:0] {
        AM_IMP     = 4'd0,
        AM_IMM     = 4'd1,
        AM_ABS     = 4'd2,
        AM_ABSX    = 4'd3,
        AM_ABSY    = 4'd4,
        AM_DP      = 4'd5,
        AM_DPX     = 4'd6,
        AM_DPY     = 4'd7,
        AM_DPIND   = 4'd8,
        AM_DPINDX  = 4'd9,
        AM_DPINDY  = 4'd10,
        AM_DPLONG  = 4'd11,
        AM_DPLONGY = 4'd12,
        AM_SR      = 4'd13,
        AM_SRINDY  = 4'd14,
        AM_REL     = 4'd15
    } addr_mode_e;

    typedef struct packed {
        logic m;
        logic x;
        logic e;
    } cpu_flags_t;

    typedef struct packed {
        logic [BYTE_W-1:0] base_hi;
        logic [BYTE_W-1:0] ea_hi;
        logic [BYTE_W-1:0] pc_hi;
    } addr_bytes_t;

    typedef struct packed {
        logic [PEN_W-1:0] width;
        logic [PEN_W-1:0] addr;
        logic [PEN_W-1:0] flow;
    } pen_set_t;

    function automatic logic is_dp_mode(input addr_mode_e am);
        return (am >= AM_DP) && (am <= AM_DPLONGY);
    endfunction

    function automatic logic is_idx_read_mode(input addr_mode_e am);
        return (am == AM_ABSX) || (am == AM_ABSY) ||
               (am == AM_DPINDY) || (am == AM_DPLONGY);
    endfunction

    function automatic logic is_read_cls(input instr_cls_e c);
        return (c == CLS_ACC) || (c == CLS_IDX);
    endfunction

    function automatic logic [PEN_W-1:0] bit2pen(input logic b);
        return {{(PEN_W-1){1'b0}}, b};
    endfunction

endpackage

// File: rtl/cyc_width_pen.sv
module cyc_width_pen
    import cyc_pkg::*;
(
    input  instr_cls_e       cls_i,
    input  cpu_flags_t       flags_i,
    output logic [PEN_W-1:0] pen_o
);
    always_comb begin
        pen_o = '0;
        unique case (cls_i)
            CLS_ACC, CLS_STORE: pen_o = bit2pen(!flags_i.m);
            CLS_RMW:            pen_o = flags_i.m ? PEN_W'(0) : PEN_W'(2);
            CLS_TRAP:           pen_o = bit2pen(!flags_i.e);
            CLS_IDX:            pen_o = bit2pen(!flags_i.x);
            default:            pen_o = '0;
        endcase
    end
endmodule

// File: rtl/cyc_addr_pen.sv
module cyc_addr_pen
    import cyc_pkg::*;
(
    input  instr_cls_e        cls_i,
    input  addr_mode_e        mode_i,
    input  cpu_flags_t        flags_i,
    input  logic [BYTE_W-1:0] dp_low_i,
    input  addr_bytes_t       bytes_i,
    output logic [PEN_W-1:0]  pen_o
);
    logic dp_unaligned;
    logic page_cross;
    logic dp_part;
    logic idx_part;

    assign dp_unaligned = |dp_low_i;
    assign page_cross   = bytes_i.base_hi != bytes_i.ea_hi;

    always_comb begin
        dp_part  = 1'b0;
        idx_part = 1'b0;
        if (cls_i != CLS_FIXED) begin
            if (is_dp_mode(mode_i))
                dp_part = dp_unaligned;
            if (mode_i == AM_SR || mode_i == AM_SRINDY)
                dp_part = 1'b1;
            if (is_read_cls(cls_i)) begin
                if (is_idx_read_mode(mode_i))
                    idx_part = !flags_i.x || page_cross;
                if (mode_i == AM_SRINDY)
                    idx_part = 1'b1;
            end
        end
        pen_o = bit2pen(dp_part) + bit2pen(idx_part);
    end
endmodule

// File: rtl/cyc_flow_pen.sv
module cyc_flow_pen
    import cyc_pkg::*;
(
    input  instr_cls_e        cls_i,
    input  addr_mode_e        mode_i,
    input  logic              taken_i,
    input  cpu_flags_t        flags_i,
    input  addr_bytes_t       bytes_i,
    output logic [PEN_W-1:0]  pen_o
);
    logic is_branch;
    logic far_emul;

    assign is_branch = (cls_i == CLS_BRANCH) && (mode_i == AM_REL);
    assign far_emul  = flags_i.e && (bytes_i.ea_hi != bytes_i.pc_hi);

    always_comb begin
        pen_o = '0;
        if (is_branch && taken_i)
            pen_o = bit2pen(1'b1) + bit2pen(far_emul);
    end
endmodule

// File: rtl/cyc_penalty_calc.sv
module cyc_penalty_calc
    import cyc_pkg::*;
#(
    parameter int CNT_W = 4,
    localparam int OUT_W = CNT_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [3:0]        cls,
    input  logic [3:0]        mode,
    input  logic [CNT_W-1:0]  base_cnt,
    input  logic              flag_m,
    input  logic              flag_x,
    input  logic              flag_e,
    input  logic [7:0]        dp_low,
    input  logic [7:0]        base_hi,
    input  logic [7:0]        ea_hi,
    input  logic [7:0]        pc_hi,
    input  logic              br_taken,
    output logic              out_valid,
    output logic [OUT_W-1:0]  out_cycles
);
    instr_cls_e  cls_e;
    addr_mode_e  mode_e;
    cpu_flags_t  flags;
    addr_bytes_t bytes;
    pen_set_t    pens;
    logic [OUT_W-1:0] total;

    assign cls_e  = instr_cls_e'(cls);
    assign mode_e = addr_mode_e'(mode);
    assign flags  = '{m: flag_m, x: flag_x, e: flag_e};
    assign bytes  = '{base_hi: base_hi, ea_hi: ea_hi, pc_hi: pc_hi};

    cyc_width_pen u_width (
        .cls_i   (cls_e),
        .flags_i (flags),
        .pen_o   (pens.width)
    );

    cyc_addr_pen u_addr (
        .cls_i    (cls_e),
        .mode_i   (mode_e),
        .flags_i  (flags),
        .dp_low_i (dp_low),
        .bytes_i  (bytes),
        .pen_o    (pens.addr)
    );

    cyc_flow_pen u_flow (
        .cls_i   (cls_e),
        .mode_i  (mode_e),
        .taken_i (br_taken),
        .flags_i (flags),
        .bytes_i (bytes),
        .pen_o   (pens.flow)
    );

    always_comb begin
        if (cls_e == CLS_FIXED)
            total = OUT_W'(FIXED_CYCLES);
        else
            total = OUT_W'(base_cnt) + OUT_W'(pens.width)
                  + OUT_W'(pens.addr) + OUT_W'(pens.flow);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_cycles <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                out_cycles <= total;
        end
    end

    assert_pulse_R1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    assert_idle_R1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_cycles));
    assert_fixed_R11: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cls == 4'd7) |=> out_cycles == OUT_W'(FIXED_CYCLES));
    assert_rmw_narrow_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cls == 4'd3 && flag_m && mode == 4'd2)
        |=> out_cycles == OUT_W'($past(base_cnt)));
    assert_no_shrink_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cls != 4'd7) |=> out_cycles >= OUT_W'($past(base_cnt)));
    assert_store_idx_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cls == 4'd2 && flag_m && mode == 4'd3)
        |=> out_cycles == OUT_W'($past(base_cnt)));
endmodule

// File: tb/tb_cyc_penalty_calc.sv
module tb_cyc_penalty_calc;
    localparam int CNT_W = 4;
    localparam int OUT_W = CNT_W + 1;

    logic clk = 1'b0;
    logic rst;
    logic in_valid;
    logic [3:0] cls, mode;
    logic [CNT_W-1:0] base_cnt;
    logic flag_m, flag_x, flag_e, br_taken;
    logic [7:0] dp_low, base_hi, ea_hi, pc_hi;
    logic out_valid;
    logic [OUT_W-1:0] out_cycles;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    cyc_penalty_calc #(.CNT_W(CNT_W)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .cls(cls), .mode(mode),
        .base_cnt(base_cnt), .flag_m(flag_m), .flag_x(flag_x), .flag_e(flag_e),
        .dp_low(dp_low), .base_hi(base_hi), .ea_hi(ea_hi), .pc_hi(pc_hi),
        .br_taken(br_taken), .out_valid(out_valid), .out_cycles(out_cycles)
    );

    function automatic int model(input int c, input int md, input int b,
                                 input bit m, input bit x, input bit e,
                                 input int dpl, input int bh, input int eh,
                                 input int ph, input bit tk);
        int t = b;
        bit rd = (c == 1) || (c == 6);
        if (c == 7) return 3;
        if ((c == 1 || c == 2) && !m) t += 1;
        if (c == 3 && !m) t += 2;
        if (c == 5 && !e) t += 1;
        if (c == 6 && !x) t += 1;
        if (md >= 5 && md <= 12 && dpl != 0) t += 1;
        if (md == 13 || md == 14) t += 1;
        if (md == 14 && rd) t += 1;
        if (rd && (md == 3 || md == 4 || md == 10 || md == 12) && (!x || bh != eh)) t += 1;
        if (c == 4 && md == 15 && tk) begin
            t += 1;
            if (e && eh != ph) t += 1;
        end
        return t;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run(input string tag, input int c, input int md, input int b,
                       input bit m, input bit x, input bit e, input int dpl,
                       input int bh, input int eh, input int ph, input bit tk);
        int exp;
        @(negedge clk);
        in_valid = 1'b1; cls = 4'(c); mode = 4'(md); base_cnt = CNT_W'(b);
        flag_m = m; flag_x = x; flag_e = e; dp_low = 8'(dpl);
        base_hi = 8'(bh); ea_hi = 8'(eh); pc_hi = 8'(ph); br_taken = tk;
        exp = model(c, md, b, m, x, e, dpl, bh, eh, ph, tk);
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " valid"}, int'(out_valid), 1);
        check(tag, int'(out_cycles), exp);
    endtask

    initial begin
        #800000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int seed = 32'h5eed_1234;
        int prev;
        void'($urandom(seed));
        rst = 1'b1; in_valid = 1'b0; cls = '0; mode = '0; base_cnt = '0;
        flag_m = 1'b1; flag_x = 1'b1; flag_e = 1'b1; dp_low = '0;
        base_hi = '0; ea_hi = '0; pc_hi = '0; br_taken = 1'b0;
        repeat (3) @(negedge clk);
        check("R12 reset valid", int'(out_valid), 0);
        check("R12 reset cycles", int'(out_cycles), 0);
        rst = 1'b0;

        run("R12 class0", 0, 2, 4, 0, 0, 0, 5, 1, 2, 3, 1);
        run("R2 acc16", 1, 2, 4, 0, 1, 1, 0, 0, 0, 0, 0);
        run("R2 acc8", 1, 2, 4, 1, 1, 1, 0, 0, 0, 0, 0);
        run("R2 store16", 2, 2, 4, 0, 1, 1, 0, 0, 0, 0, 0);
        run("R3 dp unaligned", 1, 5, 3, 1, 1, 1, 8'h01, 0, 0, 0, 0);
        run("R3 dp aligned", 1, 5, 3, 1, 1, 1, 0, 0, 0, 0, 0);
        run("R3 dplongy rmw", 3, 12, 6, 1, 1, 1, 8'h80, 0, 0, 0, 0);
        run("R4 absx cross", 1, 3, 4, 1, 1, 1, 0, 8'h12, 8'h13, 0, 0);
        run("R4 absy x16", 6, 4, 4, 1, 0, 1, 0, 8'h12, 8'h12, 0, 0);
        run("R4 absx same", 1, 3, 4, 1, 1, 1, 0, 8'h40, 8'h40, 0, 0);
        run("R4 stack3", 1, 12, 6, 0, 0, 1, 8'hFF, 8'h00, 8'h01, 0, 0);
        run("R5 store absx", 2, 3, 5, 1, 0, 1, 0, 8'h10, 8'h11, 0, 0);
        run("R5 rmw absx", 3, 3, 7, 1, 0, 1, 0, 8'h10, 8'h11, 0, 0);
        run("R6 rmw16", 3, 2, 6, 0, 1, 1, 0, 0, 0, 0, 0);
        run("R6 rmw8", 3, 2, 6, 1, 1, 1, 0, 0, 0, 0, 0);
        run("R7 not taken", 4, 15, 2, 1, 1, 1, 0, 0, 8'h05, 8'h04, 0);
        run("R7 taken near", 4, 15, 2, 1, 1, 1, 0, 0, 8'h04, 8'h04, 1);
        run("R7 taken far emu", 4, 15, 2, 1, 1, 1, 0, 0, 8'h05, 8'h04, 1);
        run("R7 taken far native", 4, 15, 2, 1, 1, 0, 0, 0, 8'h05, 8'h04, 1);
        run("R8 trap native", 5, 0, 7, 1, 1, 0, 0, 0, 0, 0, 0);
        run("R8 trap emu", 5, 0, 7, 1, 1, 1, 0, 0, 0, 0, 0);
        run("R9 idx16", 6, 1, 2, 1, 0, 1, 0, 0, 0, 0, 0);
        run("R10 sr", 1, 13, 4, 1, 1, 1, 0, 0, 0, 0, 0);
        run("R10 srindy read", 1, 14, 7, 1, 1, 1, 0, 8'h01, 8'h01, 0, 0);
        run("R10 srindy store", 2, 14, 7, 1, 1, 1, 0, 8'h01, 8'h02, 0, 0);
        run("R11 fixed", 7, 0, 15, 0, 0, 0, 8'h33, 1, 2, 3, 1);

        // R1: hold while idle, inputs wiggling
        prev = int'(out_cycles);
        @(negedge clk);
        cls = 4'd3; mode = 4'd12; base_cnt = 4'd9; flag_m = 1'b0; dp_low = 8'h44;
        @(negedge clk);
        @(negedge clk);
        check("R1 idle valid", int'(out_valid), 0);
        check("R1 hold", int'(out_cycles), prev);

        for (int i = 0; i < 400; i++) begin
            int c = int'($urandom_range(0, 7));
            int md = int'($urandom_range(0, 15));
            int bh = int'($urandom_range(0, 255));
            int eh = ($urandom_range(0, 1) == 1) ? bh : int'($urandom_range(0, 255));
            int ph = ($urandom_range(0, 1) == 1) ? eh : int'($urandom_range(0, 255));
            int dpl = ($urandom_range(0, 2) == 0) ? 0 : int'($urandom_range(0, 255));
            run("R1 random", c, md, int'($urandom_range(1, 12)),
                1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                1'($urandom_range(0, 1)), dpl, bh, eh, ph,
                1'($urandom_range(0, 1)));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule